// File: doc/BRIEF.md
# Packed 4-Bit Weight Group Dot-Product Engine

This engine computes one scaled dot product between a group of eight signed 4-bit weights and eight signed 16-bit activations. The weights arrive packed two per byte in a single 32-bit word. One unsigned fractional scale applies to the whole group. A single valid/ready handshake delivers the word, the activation vector and the scale together. The engine then walks the four bytes, one byte per clock. Each byte is split into two nibbles, and each nibble is sign-extended and multiplied by its activation. The two products join a 24-bit signed integer accumulator.

After the last byte, one extra cycle multiplies the accumulator by the scale. The result is presented on a registered output with a done flag, and it is held until the consumer takes it. Only then is a new group accepted. A separate clear input zeroes the accumulator at any edge. It does not disturb the captured scale or the byte sequence, so a group that is cleared part-way still finishes and scales what comes after the clear.

Top module: `int4_group_dot`

## Requirements
- R1: Byte k of `in_weights` is bits [8k+7:8k]. Its lower nibble is weight 2k and its upper nibble is weight 2k+1. Activation lane i is bits [16i+15:16i] of `in_acts`. A byte of 0x6D therefore carries the weights -3 (even lane) and 6 (odd lane).
- R2: Each nibble is 4-bit two's complement. A raw value n of 8 or more stands for n-16, which gives the range -8..7.
- R3: The accumulator holds the exact signed sum of the eight weight×activation products in 24 bits. The extreme cases, with all weights at -8 against -32768 and all at 7 against 32767, come out exact.
- R4: `out_result` is the low 32 bits of the 40-bit signed product of the accumulator and `in_scale`. The scale is read as unsigned Q0.16, so the result is Q16.16 with the top integer bits dropped.
- R5: `out_done` rises exactly five clock edges after the edge that accepts a group: four byte steps and one scale step.
- R6: `in_ready` is high only while the engine is idle. While a group is in flight or a result is held, `in_valid` and the input buses are ignored. A held `out_result` stays stable until it is taken.
- R7: When `out_take` is high while `out_done` is high, `out_done` falls and `in_ready` rises at that edge.
- R8: `clear` zeroes the accumulator at the edge where it is high. Products added at that edge or earlier are dropped. The remaining bytes still accumulate and are scaled by the group's captured scale.
- R9: After reset, `in_ready` is 1, `out_done` is 0 and `out_result` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clear | input | 1 | Zero the accumulator at this edge |
| in_valid | input | 1 | Group offered |
| in_ready | output | 1 | Engine idle, group will be taken |
| in_weights | input | 32 | Eight packed 4-bit weights |
| in_acts | input | 128 | Eight signed 16-bit activations |
| in_scale | input | 16 | Unsigned Q0.16 group scale |
| out_done | output | 1 | Result valid and held |
| out_take | input | 1 | Consumer takes the result |
| out_result | output | 32 | Scaled dot product, Q16.16 |

## Verification
The bench sweeps every byte value through all four weight positions. This exposes a design that swaps the nibble order, which would pair each weight with its neighbour's activation. It also exposes one that zero-extends a nibble, which would turn -8 into +8. Single-lane groups and the two full-scale extremes catch a lane mapped to the wrong activation, and an accumulator that wraps. A clear is placed at each of the four byte steps, which catches a design that drops the wrong bytes or loses the scale. Groups offered while the engine is busy or holding a result must leave that result untouched, and latency is checked to the exact edge.

// File: rtl/int4dot_pkg.sv
package int4dot_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_SCALE = 2'd2,
    ST_DONE  = 2'd3
  } eng_state_t;
endpackage

// File: rtl/int4dot_unpack.sv
module int4dot_unpack #(
  parameter int NIB_W = 4,
  parameter int NIBS  = 2,
  parameter int EXT_W = 20
) (
  input  logic [NIB_W*NIBS-1:0] byte_i,
  output logic [EXT_W*NIBS-1:0] wts_o
);
  for (genvar g = 0; g < NIBS; g++) begin : g_nib
    logic [NIB_W-1:0] raw;
    assign raw = byte_i[g*NIB_W +: NIB_W];
    // Two's complement nibble: replicate its top bit
    assign wts_o[g*EXT_W +: EXT_W] = {{(EXT_W-NIB_W){raw[NIB_W-1]}}, raw};
  end
endmodule

// File: rtl/int4dot_pair_mac.sv
module int4dot_pair_mac #(
  parameter int NIBS  = 2,
  parameter int ACT_W = 16,
  parameter int EXT_W = 20,
  parameter int SUM_W = 24
) (
  input  logic [EXT_W*NIBS-1:0]   wts_i,
  input  logic [ACT_W*NIBS-1:0]   acts_i,
  output logic signed [SUM_W-1:0] sum_o
);
  logic [SUM_W*NIBS-1:0] prods;

  for (genvar g = 0; g < NIBS; g++) begin : g_mul
    logic signed [EXT_W-1:0] w_ext;
    logic signed [EXT_W-1:0] a_ext;
    logic signed [EXT_W-1:0] p;
    assign w_ext = $signed(wts_i[g*EXT_W +: EXT_W]);
    assign a_ext = $signed({{(EXT_W-ACT_W){acts_i[g*ACT_W+ACT_W-1]}},
                            acts_i[g*ACT_W +: ACT_W]});
    assign p = w_ext * a_ext;
    assign prods[g*SUM_W +: SUM_W] = {{(SUM_W-EXT_W){p[EXT_W-1]}}, p};
  end

  always_comb begin
    sum_o = '0;
    for (int i = 0; i < NIBS; i++) begin
      sum_o = sum_o + $signed(prods[i*SUM_W +: SUM_W]);
    end
  end
endmodule

// File: rtl/int4dot_ctrl.sv
module int4dot_ctrl
  import int4dot_pkg::*;
#(
  parameter int STEPS  = 4,
  parameter int STEP_W = (STEPS > 1) ? $clog2(STEPS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              out_take,
  output logic              in_ready,
  output logic              accept_o,
  output logic              acc_en_o,
  output logic              scale_en_o,
  output logic              done_o,
  output logic [STEP_W-1:0] step_o
);
  localparam logic [STEP_W-1:0] LAST = STEP_W'(STEPS - 1);

  eng_state_t state_q;
  logic [STEP_W-1:0] step_q;

  assign in_ready   = (state_q == ST_IDLE);
  assign accept_o   = in_ready && in_valid;
  assign acc_en_o   = (state_q == ST_RUN);
  assign scale_en_o = (state_q == ST_SCALE);
  assign done_o     = (state_q == ST_DONE);
  assign step_o     = step_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          step_q <= '0;
          if (in_valid) state_q <= ST_RUN;
        end
        ST_RUN: begin
          step_q <= step_q + 1'b1;
          if (step_q == LAST) state_q <= ST_SCALE;
        end
        ST_SCALE: state_q <= ST_DONE;
        ST_DONE:  if (out_take) state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/int4dot_scale.sv
module int4dot_scale #(
  parameter int ACC_W   = 24,
  parameter int SCALE_W = 16,
  parameter int OUT_W   = 32,
  parameter int MUL_W   = ACC_W + SCALE_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic signed [ACC_W-1:0] acc_i,
  input  logic [SCALE_W-1:0]      scale_i,
  output logic [OUT_W-1:0]        result_o
);
  logic signed [MUL_W-1:0] acc_x;
  logic signed [MUL_W-1:0] scl_x;
  logic signed [MUL_W-1:0] prod;

  assign acc_x = {{(MUL_W-ACC_W){acc_i[ACC_W-1]}}, acc_i};
  assign scl_x = $signed({{(MUL_W-SCALE_W){1'b0}}, scale_i});
  assign prod  = acc_x * scl_x;

  always_ff @(posedge clk) begin
    if (rst)     result_o <= '0;
    else if (en) result_o <= prod[OUT_W-1:0];
  end
endmodule

// File: rtl/int4_group_dot.sv
module int4_group_dot #(
  parameter int NIB_W   = 4,
  parameter int NIBS    = 2,
  parameter int STEPS   = 4,
  parameter int ACT_W   = 16,
  parameter int ACC_W   = 24,
  parameter int SCALE_W = 16,
  parameter int OUT_W   = 32,
  localparam int BYTE_W = NIB_W * NIBS,
  localparam int WORD_W = BYTE_W * STEPS,
  localparam int LANES  = NIBS * STEPS,
  localparam int ACTS_W = ACT_W * LANES,
  localparam int EXT_W  = NIB_W + ACT_W,
  localparam int STEP_W = (STEPS > 1) ? $clog2(STEPS) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clear,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [WORD_W-1:0]  in_weights,
  input  logic [ACTS_W-1:0]  in_acts,
  input  logic [SCALE_W-1:0] in_scale,
  output logic               out_done,
  input  logic               out_take,
  output logic [OUT_W-1:0]   out_result
);
  logic               accept, acc_en, scale_en;
  logic [STEP_W-1:0]  step;
  logic [WORD_W-1:0]  wts_q;
  logic [ACTS_W-1:0]  acts_q;
  logic [SCALE_W-1:0] scale_q;
  logic signed [ACC_W-1:0] acc_q;
  logic [BYTE_W-1:0]       cur_byte;
  logic [ACT_W*NIBS-1:0]   cur_acts;
  logic [EXT_W*NIBS-1:0]   cur_wts;
  logic signed [ACC_W-1:0] pair_sum;

  int4dot_ctrl #(.STEPS(STEPS), .STEP_W(STEP_W)) i_ctrl (
    .clk(clk), .rst(rst), .in_valid(in_valid), .out_take(out_take),
    .in_ready(in_ready), .accept_o(accept), .acc_en_o(acc_en),
    .scale_en_o(scale_en), .done_o(out_done), .step_o(step)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wts_q   <= '0;
      acts_q  <= '0;
      scale_q <= '0;
    end else if (accept) begin
      wts_q   <= in_weights;
      acts_q  <= in_acts;
      scale_q <= in_scale;
    end
  end

  assign cur_byte = wts_q[step*BYTE_W +: BYTE_W];
  assign cur_acts = acts_q[step*(ACT_W*NIBS) +: ACT_W*NIBS];

  int4dot_unpack #(.NIB_W(NIB_W), .NIBS(NIBS), .EXT_W(EXT_W)) i_unpack (
    .byte_i(cur_byte), .wts_o(cur_wts)
  );

  int4dot_pair_mac #(.NIBS(NIBS), .ACT_W(ACT_W), .EXT_W(EXT_W),
                     .SUM_W(ACC_W)) i_mac (
    .wts_i(cur_wts), .acts_i(cur_acts), .sum_o(pair_sum)
  );

  // clear outranks accumulation; scale and step are left alone
  always_ff @(posedge clk) begin
    if (rst || clear || accept) acc_q <= '0;
    else if (acc_en)            acc_q <= acc_q + pair_sum;
  end

  int4dot_scale #(.ACC_W(ACC_W), .SCALE_W(SCALE_W), .OUT_W(OUT_W)) i_scale (
    .clk(clk), .rst(rst), .en(scale_en), .acc_i(acc_q),
    .scale_i(scale_q), .result_o(out_result)
  );
endmodule

// File: rtl/int4dot_chk.sv
module int4dot_chk #(
  parameter int STEPS = 4,
  parameter int OUT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_done,
  input logic             out_take,
  input logic [OUT_W-1:0] out_result
);
  localparam logic [7:0] LAT = 8'(STEPS + 1);
  logic [7:0] since_acc;

  always_ff @(posedge clk) begin
    if (rst)                        since_acc <= '1;
    else if (in_valid && in_ready)  since_acc <= '0;
    else if (since_acc != 8'hFF)    since_acc <= since_acc + 1'b1;
  end

  // R9
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (in_ready && !out_done));

  // R6
  accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !in_ready);

  // R6
  ready_held_chk: assert property (@(posedge clk) disable iff (rst)
    out_done |-> !in_ready);

  // R5
  done_latency_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(out_done) |-> (since_acc == LAT));

  // R6
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_done && $past(out_done && !out_take)) |-> $stable(out_result));

  // R7
  take_release_chk: assert property (@(posedge clk) disable iff (rst)
    (out_done && out_take) |=> (!out_done && in_ready));
endmodule

bind int4_group_dot int4dot_chk #(.STEPS(STEPS), .OUT_W(OUT_W)) i_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .out_done(out_done), .out_take(out_take), .out_result(out_result)
);

// File: tb/test_int4_group_dot.sv
`timescale 1ns/1ps
module test_int4_group_dot;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         clear = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [31:0]  in_weights = '0;
  logic [127:0] in_acts = '0;
  logic [15:0]  in_scale = '0;
  logic         out_done;
  logic         out_take = 1'b0;
  logic [31:0]  out_result;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  int4_group_dot i_int4_group_dot (
    .clk(clk), .rst(rst), .clear(clear), .in_valid(in_valid),
    .in_ready(in_ready), .in_weights(in_weights), .in_acts(in_acts),
    .in_scale(in_scale), .out_done(out_done), .out_take(out_take),
    .out_result(out_result)
  );

  task automatic check(input bit ok, input string req, input longint act,
                       input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model(input logic [31:0] w,
      input logic [127:0] a, input logic [15:0] s, input int first_byte);
    longint acc = 0;
    longint p;
    for (int i = 0; i < 8; i++) begin
      logic [3:0] n = w[4*i +: 4];
      int wv = (n >= 8) ? int'(n) - 16 : int'(n);
      int av = int'($signed(a[16*i +: 16]));
      if (i / 2 >= first_byte) acc += longint'(wv) * longint'(av);
    end
    p = acc * longint'(s);
    return p[31:0];
  endfunction

  // clr_at = j (1..4) clears at the j-th edge after acceptance
  task automatic run_group(input logic [31:0] w, input logic [127:0] a,
      input logic [15:0] s, input int clr_at, input bit junk, input string req);
    logic [31:0] exp = model(w, a, s, clr_at);
    logic [31:0] held;
    @(negedge clk);
    in_valid = 1'b1; in_weights = w; in_acts = a; in_scale = s;
    check(in_ready === 1'b1, "R6 ready idle", longint'(in_ready), 1);
    @(posedge clk);
    @(negedge clk);
    if (junk) begin
      in_weights = ~w; in_acts = ~a; in_scale = ~s;
    end else in_valid = 1'b0;
    for (int k = 1; k <= 4; k++) begin
      clear = (k == clr_at);
      @(posedge clk);
      @(negedge clk);
    end
    clear = 1'b0;
    check(out_done === 1'b0, "R5 early done", longint'(out_done), 0);
    @(posedge clk);
    @(negedge clk);
    check(out_done === 1'b1, "R5 done latency", longint'(out_done), 1);
    check(out_result === exp, req, longint'(out_result), longint'(exp));
    held = out_result;
    @(posedge clk);
    @(negedge clk);
    check(out_result === held && in_ready === 1'b0 && out_done === 1'b1,
          "R6 hold", longint'(out_result), longint'(held));
    out_take = 1'b1; in_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    out_take = 1'b0;
    check(in_ready === 1'b1 && out_done === 1'b0, "R7 take",
          longint'({in_ready, out_done}), 2);
  endtask

  function automatic logic [127:0] ramp_acts(input int base, input int step);
    logic [127:0] v;
    for (int i = 0; i < 8; i++) v[16*i +: 16] = 16'(base + i * step);
    return v;
  endfunction

  initial begin
    #(200000 * 5.0);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R9 reset state
    check(in_ready === 1'b1 && out_done === 1'b0 && out_result === 32'h0,
          "R9 reset", longint'(out_result), 0);

    // R1 packing example: 0x6D -> (-3, 6)
    run_group(32'h0000_006D, {96'h0, 16'd1000, 16'd1}, 16'h0001, 0, 0,
              "R1 R2 0x6D pair");
    check(model(32'h6D, {96'h0, 16'd1000, 16'd1}, 16'h1, 0) == 32'd5997,
          "R1 model", 0, 0);

    // R1 lane isolation
    for (int l = 0; l < 8; l++)
      run_group(32'h1 << (4 * l), ramp_acts(-700, 311), 16'h8000, 0, 0,
                "R1 lane map");

    // R2 every byte in every position
    for (int b = 0; b < 256; b++)
      run_group({4{b[7:0]}}, ramp_acts(-1234, 617), 16'hFFFF, 0, 0,
                "R2 nibble sweep");

    // R3 extremes
    run_group(32'h8888_8888, {8{16'h8000}}, 16'hFFFF, 0, 0, "R3 min extreme");
    run_group(32'h7777_7777, {8{16'h7FFF}}, 16'hFFFF, 0, 0, "R3 max extreme");
    run_group(32'h7777_7777, {8{16'h8000}}, 16'h0001, 0, 0, "R3 mixed extreme");

    // R4 scale corners
    run_group(32'h1234_ABCD, ramp_acts(-9000, 2500), 16'h0000, 0, 0, "R4 scale 0");
    run_group(32'h1234_ABCD, ramp_acts(-9000, 2500), 16'h0001, 0, 0, "R4 scale 1");
    run_group(32'h1234_ABCD, ramp_acts(-9000, 2500), 16'h8000, 0, 0, "R4 scale half");
    run_group(32'h1234_ABCD, ramp_acts(-9000, 2500), 16'hFFFF, 0, 0, "R4 scale max");

    // R8 clear at each byte step
    for (int j = 1; j <= 4; j++)
      run_group(32'h9F3C_51E7, ramp_acts(3000, -1100), 16'h4321, j, 0,
                "R8 clear step");

    // R6 inputs ignored while busy or holding
    run_group(32'hC3A5_5A3C, ramp_acts(-32768, 8191), 16'h7ABC, 0, 1,
              "R6 busy ignore");

    // R3 R4 random groups
    for (int r = 0; r < 150; r++) begin
      logic [127:0] a;
      for (int i = 0; i < 4; i++) a[32*i +: 32] = $urandom;
      run_group($urandom, a, 16'($urandom), 0, (r % 5) == 0, "R3 R4 random");
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule